// File: doc/BRIEF.md
# Character-Cell Raster Address Generator

This block produces the display-memory byte addresses that a video fetch engine reads, in raster order, for a bitmap screen stored as character cells eight scanlines tall. Inside a cell the eight bytes for its eight scanlines sit at consecutive addresses. Cells follow one another left to right, and rows of cells follow one another top to bottom. As a result, consecutive bytes on one scanline are 8 addresses apart. Moving down one scanline inside a cell adds one to the address.

A start-of-frame pulse latches the layout code and restarts the scan at the layout's screen base. The address leaves the block as a valid/ready stream. `addr_valid_o` is high while a frame is in progress, and `fetch_en_i` is the consumer's ready. A byte counts as issued in a cycle where both are high. While `fetch_en_i` is low, the address and the start-of-scanline flag hold their values. A one-cycle end-of-frame flag follows the last issued byte.

Top module: `cellscan_addr_gen`

## Requirements
- R1: After reset, `addr_valid_o`, `sol_o` and `eof_o` are low and stay low until a start-of-frame pulse.
- R2: A cycle with `sof_i` high latches `mode_i`, returns to the first byte (row 0, scanline 0, column 0) and sets `addr_valid_o` high on the next cycle. This also applies in the middle of a frame, and `sof_i` overrides a simultaneous fetch.
- R3: Layout codes map as follows. Codes 0, 1 and 2 use base 0x3000, 640 bytes per row, 80 columns and 32 rows. Code 3 uses base 0x4000, 640 bytes, 80 columns and 25 rows. Codes 4 and 5 use base 0x5800, 320 bytes, 40 columns and 32 rows. Code 6 uses base 0x6000, 320 bytes, 40 columns and 25 rows. Code 7 behaves as code 6.
- R4: The address for cell row r, scanline s within the cell and column c is base + r·bytes_per_row + 8·c + s.
- R5: Each issued byte advances the column. After the last column the scanline within the cell advances. After scanline 7 the cell row advances.
- R6: While `addr_valid_o` is high and `fetch_en_i` is low, `addr_o` and `sol_o` keep their values and no byte is consumed.
- R7: A change of `mode_i` has no effect until the next start-of-frame pulse.
- R8: `sol_o` is high exactly when the pending address is column 0 of a scanline.
- R9: When the last byte of the last scanline is issued, `addr_valid_o` falls on the next cycle and `eof_o` is high for exactly that one cycle.
- R10: Every valid address lies between the layout's base and 0x7FFF. A computed sum above 0x7FFF is reduced by the layout's screen size (0x8000 minus base).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Layout code, sampled on start of frame |
| sof_i | input | 1 | Start-of-frame pulse |
| fetch_en_i | input | 1 | Ready: consumer accepts the current address |
| addr_o | output | 16 | Display-memory byte address |
| addr_valid_o | output | 1 | Address is valid (frame in progress) |
| sol_o | output | 1 | Current address starts a scanline |
| eof_o | output | 1 | One-cycle pulse after the last byte of the frame |

## Verification
On every cycle the assertions check the following: addresses stay inside the screen window, the address and the latched layout hold under back-pressure, the in-line step is 8, a start pulse leads to column 0 of a scanline, and the end-of-frame flag is a single-cycle pulse while the stream is idle. They cannot show that the whole sequence is right. That covers the exact address of each byte, the wrap from column to scanline to row, and the row count of each layout. The bench shows these by comparing complete frames in several layouts, under random ready patterns, against an address model of its own. The bench's scenarios also show that a restart in the middle of a frame works and that a changed layout code is ignored until the next start.

// File: rtl/cellscan_pkg.sv
package cellscan_pkg;
  localparam int ADDR_W   = 16;
  localparam int COL_W    = 7;
  localparam int ROW_W    = 5;
  localparam int SCAN_W   = 3;
  localparam int RB_W     = 10;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] size;
    logic [RB_W-1:0]   row_bytes;
    logic [COL_W-1:0]  last_col;
    logic [ROW_W-1:0]  last_row;
  } layout_t;

  function automatic layout_t layout_of(input logic [2:0] code);
    layout_t l;
    unique case (code)
      3'd0, 3'd1, 3'd2: begin
        l.base = 16'h3000; l.row_bytes = 10'd640; l.last_col = 7'd79; l.last_row = 5'd31;
      end
      3'd3: begin
        l.base = 16'h4000; l.row_bytes = 10'd640; l.last_col = 7'd79; l.last_row = 5'd24;
      end
      3'd4, 3'd5: begin
        l.base = 16'h5800; l.row_bytes = 10'd320; l.last_col = 7'd39; l.last_row = 5'd31;
      end
      default: begin
        l.base = 16'h6000; l.row_bytes = 10'd320; l.last_col = 7'd39; l.last_row = 5'd24;
      end
    endcase
    l.size = 16'h8000 - l.base;
    return l;
  endfunction
endpackage

// File: rtl/cellscan_layout.sv
module cellscan_layout
  import cellscan_pkg::*;
(
  input  logic [2:0] mode_q,
  output layout_t    cfg
);
  always_comb cfg = layout_of(mode_q);
endmodule

// File: rtl/cellscan_raster.sv
module cellscan_raster
  import cellscan_pkg::*;
#(
  parameter int CELL_LINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof_i,
  input  logic [2:0]        mode_i,
  input  logic              fetch_en_i,
  input  layout_t           cfg,
  output logic [2:0]        mode_q,
  output logic              active,
  output logic [COL_W-1:0]  col,
  output logic [SCAN_W-1:0] scan,
  output logic [ROW_W-1:0]  row,
  output logic              eof
);
  localparam logic [SCAN_W-1:0] LAST_SCAN = SCAN_W'(CELL_LINES - 1);

  logic take, end_col, end_scan, end_frame;
  assign take      = active && fetch_en_i;
  assign end_col   = (col == cfg.last_col);
  assign end_scan  = (scan == LAST_SCAN);
  assign end_frame = end_col && end_scan && (row == cfg.last_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      active <= 1'b0;
      col    <= '0;
      scan   <= '0;
      row    <= '0;
      eof    <= 1'b0;
    end else if (sof_i) begin
      mode_q <= mode_i;
      active <= 1'b1;
      col    <= '0;
      scan   <= '0;
      row    <= '0;
      eof    <= 1'b0;
    end else begin
      eof <= take && end_frame;
      if (take) begin
        if (!end_col) begin
          col <= col + 1'b1;
        end else begin
          col <= '0;
          if (!end_scan) begin
            scan <= scan + 1'b1;
          end else begin
            scan <= '0;
            if (end_frame) begin
              active <= 1'b0;
              row    <= '0;
            end else begin
              row <= row + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cellscan_addr_calc.sv
module cellscan_addr_calc
  import cellscan_pkg::*;
#(
  parameter int               CELL_LINES = 8,
  parameter logic [ADDR_W-1:0] SCREEN_END = 16'h7FFF
) (
  input  layout_t           cfg,
  input  logic [COL_W-1:0]  col,
  input  logic [SCAN_W-1:0] scan,
  input  logic [ROW_W-1:0]  row,
  output logic [ADDR_W-1:0] addr
);
  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] row_off, col_off, sum;

  always_comb begin
    row_off = SUM_W'(row) * SUM_W'(cfg.row_bytes);
    col_off = SUM_W'(col) * SUM_W'(CELL_LINES);
    sum     = SUM_W'(cfg.base) + row_off + col_off + SUM_W'(scan);
    if (sum > SUM_W'(SCREEN_END)) addr = ADDR_W'(sum - SUM_W'(cfg.size));
    else                          addr = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/cellscan_addr_gen.sv
module cellscan_addr_gen
  import cellscan_pkg::*;
#(
  parameter int CELL_LINES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  mode_i,
  input  logic        sof_i,
  input  logic        fetch_en_i,
  output logic [15:0] addr_o,
  output logic        addr_valid_o,
  output logic        sol_o,
  output logic        eof_o
);
  layout_t           cfg;
  logic [2:0]        mode_q;
  logic              active;
  logic [COL_W-1:0]  col;
  logic [SCAN_W-1:0] scan;
  logic [ROW_W-1:0]  row;
  logic              eof;
  logic [ADDR_W-1:0] addr;

  cellscan_layout u_layout (.mode_q(mode_q), .cfg(cfg));

  cellscan_raster #(.CELL_LINES(CELL_LINES)) u_raster (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .mode_i(mode_i),
    .fetch_en_i(fetch_en_i), .cfg(cfg), .mode_q(mode_q), .active(active),
    .col(col), .scan(scan), .row(row), .eof(eof)
  );

  cellscan_addr_calc #(.CELL_LINES(CELL_LINES)) u_calc (
    .cfg(cfg), .col(col), .scan(scan), .row(row), .addr(addr)
  );

  assign addr_o       = addr;
  assign addr_valid_o = active;
  assign sol_o        = active && (col == '0);
  assign eof_o        = eof;
endmodule

// File: rtl/cellscan_addr_gen_chk.sv
module cellscan_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sof_i,
  input logic        fetch_en_i,
  input logic [15:0] addr_o,
  input logic        addr_valid_o,
  input logic        sol_o,
  input logic        eof_o,
  input logic [2:0]  mode_q,
  input logic [15:0] base_q
);
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_o |-> (addr_o >= base_q && addr_o <= 16'h7FFF)); // R10
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !fetch_en_i && !sof_i) |=> (addr_valid_o && $stable(addr_o) && $stable(sol_o))); // R6
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_i |=> $stable(mode_q)); // R7
  AST_STEP_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && fetch_en_i && !sof_i) |=> (!addr_valid_o || sol_o || addr_o == $past(addr_o) + 16'd8)); // R4
  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |=> (addr_valid_o && sol_o && !eof_o)); // R2
  AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |=> !eof_o); // R9
  AST_EOF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    eof_o |-> !addr_valid_o); // R9
  AST_SOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sol_o |-> addr_valid_o); // R8
endmodule

bind cellscan_addr_gen cellscan_addr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .fetch_en_i(fetch_en_i),
  .addr_o(addr_o), .addr_valid_o(addr_valid_o), .sol_o(sol_o), .eof_o(eof_o),
  .mode_q(mode_q), .base_q(cfg.base)
);

// File: tb/tb_cellscan_addr_gen.sv
module tb_cellscan_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_i = '0;
  logic        sof_i = 1'b0;
  logic        fetch_en_i = 1'b0;
  logic [15:0] addr_o;
  logic        addr_valid_o, sol_o, eof_o;

  int checks = 0;
  int errors = 0;
  int seed_dummy;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cellscan_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sof_i(sof_i),
    .fetch_en_i(fetch_en_i), .addr_o(addr_o), .addr_valid_o(addr_valid_o),
    .sol_o(sol_o), .eof_o(eof_o)
  );

  // R3 layout table, written independently
  function automatic int base_of(int m);
    if (m <= 2) return 'h3000;
    if (m == 3) return 'h4000;
    if (m <= 5) return 'h5800;
    return 'h6000;
  endfunction
  function automatic int cols_of(int m);
    return (m <= 3) ? 80 : 40;
  endfunction
  function automatic int rows_of(int m);
    return (m == 3 || m >= 6) ? 25 : 32;
  endfunction
  // R4 address formula
  function automatic int exp_addr(int m, int r, int s, int c);
    int a;
    a = base_of(m) + r * cols_of(m) * 8 + c * 8 + s;
    if (a > 'h7FFF) a = a - ('h8000 - base_of(m));
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic pulse_sof(input int m);
    @(negedge clk);
    mode_i = 3'(m); sof_i = 1'b1; fetch_en_i = 1'b0;
    @(negedge clk);
    sof_i = 1'b0;
  endtask

  // Run a frame of layout m; ready with probability pct; stop after limit bytes (0 = full)
  task automatic run_frame(input int m, input int pct, input int limit, input int stray_mode);
    int r = 0, s = 0, c = 0, n = 0;
    bit fin = 1'b0;
    int lm;
    lm = (m == 7) ? 6 : m;
    pulse_sof(m);
    mode_i = 3'(stray_mode); // R7: must be ignored until next start
    chk(addr_o == 16'(base_of(lm)), "R2", addr_o, base_of(lm));
    while (!fin) begin
      chk(addr_valid_o && !eof_o && (addr_o == 16'(exp_addr(lm, r, s, c))), "R4/R5/R7",
          addr_o, exp_addr(lm, r, s, c));
      chk(sol_o == (c == 0), "R8", sol_o, (c == 0));
      chk(addr_o >= 16'(base_of(lm)) && addr_o <= 16'h7FFF, "R10", addr_o, base_of(lm));
      fetch_en_i = (($urandom % 100) < pct);
      @(negedge clk);
      if (fetch_en_i) begin
        n++;
        c++;
        if (c == cols_of(lm)) begin
          c = 0; s++;
          if (s == 8) begin
            s = 0; r++;
            if (r == rows_of(lm)) fin = 1'b1;
          end
        end
      end else begin
        chk(addr_valid_o, "R6", addr_valid_o, 1);
      end
      if (limit != 0 && n >= limit) begin
        fetch_en_i = 1'b0;
        return;
      end
    end
    fetch_en_i = 1'b0;
    chk(eof_o && !addr_valid_o, "R9", {eof_o, addr_valid_o}, 2);
    @(negedge clk);
    chk(!eof_o && !addr_valid_o, "R9", {eof_o, addr_valid_o}, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    $display("FAIL watchdog: actual timeout expected completion");
    errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h1234_5678);
    repeat (3) @(negedge clk);
    chk(!addr_valid_o && !sol_o && !eof_o, "R1", {addr_valid_o, sol_o, eof_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fetch_en_i = 1'b1;
    @(negedge clk);
    chk(!addr_valid_o && !sol_o && !eof_o, "R1", {addr_valid_o, sol_o, eof_o}, 0);
    fetch_en_i = 1'b0;

    run_frame(3, 100, 0, 0);   // 25 rows, 80 columns
    run_frame(6, 50, 0, 2);    // 25 rows, 40 columns, random stalls
    run_frame(0, 100, 0, 4);   // 32 rows, 80 columns
    run_frame(5, 75, 0, 3);
    run_frame(4, 100, 0, 6);
    run_frame(1, 60, 700, 5);  // partial, then restart mid-frame (R2)
    run_frame(2, 80, 1300, 0);
    run_frame(7, 90, 900, 1);  // code 7 behaves as 6 (R3)

    // R2: sof overrides a simultaneous fetch
    pulse_sof(4);
    fetch_en_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b1; mode_i = 3'd0;
    @(negedge clk);
    sof_i = 1'b0; fetch_en_i = 1'b0;
    chk(addr_valid_o && sol_o && addr_o == 16'h3000, "R2", addr_o, 'h3000);

    // R6: long stall holds address
    fetch_en_i = 1'b1;
    repeat (5) @(negedge clk);
    fetch_en_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(addr_o == 16'h3028 && !sol_o, "R6", addr_o, 'h3028);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule